// File: doc/BRIEF.md
# Level-B Interleaved Link Demultiplexer

This block accepts a full-rate stream of 20-bit video words in which two HD data streams are interleaved word by word, and splits it into two 20-bit output links. Each link word carries a 10-bit luma sample on bits [19:10] and a 10-bit chroma sample on bits [9:0]. Link A carries the first stream (Y1/C1) and link B carries the second (Y2/C2). Each link runs at half the input word rate. Every timing reference (3FFh, 000h, 000h, XYZ) and the two line-number words after it reach each link whole and in order.

A strobe from the upstream framer marks the first word of a timing reference. The block uses it to decide which phase of the word alternation belongs to link A. It then writes alternate words into one FIFO per link. The FIFOs pass their pointers as Gray code through two-stage synchronisers, so the read side could run on a separate half-rate clock. In this build both sides run on the receive clock, and the block generates its own half-rate clock enable. Both FIFOs are read together on that enable, so the two links leave the block word-aligned.

Top module: `lvlb_link_demux`

## Requirements
- R1: While `rst_n` is low, `link_vld`, `fifo_err` and `hr_ce` are all 0.
- R2: After reset is released, `hr_ce` is 1 in the first cycle and then alternates 1, 0, 1, 0 every cycle.
- R3: Words that arrive before the first word marked by `rx_trs` are discarded and never appear on either link.
- R4: The word marked by `rx_trs` goes to link A and the word after it goes to link B. After that, words alternate A, B, A, B until the next mark restarts the pattern on link A.
- R5: A word is forwarded with its bits unchanged. Bits [19:10] stay the luma sample and bits [9:0] stay the chroma sample.
- R6: Each link emits the six words 3FFh, 000h, 000h, XYZ, LN0 and LN1 of its own stream consecutively and in input order, followed by that stream's samples in input order.
- R7: The words of links A and B that came from the same input pair appear on the outputs in the same cycle.
- R8: `link_a`, `link_b` and `link_vld` change only at the clock edge that starts a cycle with `hr_ce` = 1. They hold their values through each cycle with `hr_ce` = 0.
- R9: `link_vld` stays 0 until both FIFOs hold at least START_LVL words. From then on, under a continuous interleaved input, it is 1 in every cycle with `hr_ce` = 1.
- R10: `fifo_err` is set when a link FIFO receives a write while full, or when a read is due while the output is running and either FIFO is empty. Once set, it stays set until reset. It stays 0 under a continuous interleaved input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_word | input | 20 | Interleaved input word: luma [19:10], chroma [9:0] |
| rx_trs | input | 1 | Marks the first (3FFh) word of a timing reference |
| link_a | output | 20 | Link A word (stream 1) |
| link_b | output | 20 | Link B word (stream 2) |
| link_vld | output | 1 | Link words are valid |
| hr_ce | output | 1 | Half-rate clock enable; link outputs are fresh in cycles where it is 1 |
| fifo_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench starts the stream after an odd number of unmarked filler words, and again after an even number. This catches a design that locks the link assignment to its own write toggle or to the half-rate enable instead of to the mark. Such a design would put filler on a link, or swap Y1/C1 with Y2/C2. Every emitted pair is compared with independently built per-stream queues. A design that let the two FIFOs drift apart would show one link a word ahead of the other. A design that reordered or merged the reference words would break the six-word sequences. Between enable pulses the bench checks that the outputs hold steady. It also checks that valid never drops once streaming has begun, which an under-filled start threshold would break.

// File: rtl/lvlb_pkg.sv
package lvlb_pkg;
  localparam int GW = 16;

  function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/lvlb_ldm_steer.sv
module lvlb_ldm_steer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_trs,
  output logic         wr_a,
  output logic         wr_b
);
  logic lock_q, lock_d;
  logic last_a_q, last_a_d;
  logic sel_a;

  always_comb begin
    sel_a    = rx_trs | (lock_q & ~last_a_q);
    lock_d   = lock_q | rx_trs;
    last_a_d = sel_a;
    wr_a     = lock_d & sel_a;
    wr_b     = lock_d & ~sel_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      last_a_q <= 1'b0;
    end else begin
      lock_q   <= lock_d;
      last_a_q <= last_a_d;
    end
  end
endmodule

// File: rtl/lvlb_ldm_fifo.sv
module lvlb_ldm_fifo #(
  parameter int W  = 20,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   rd_level
);
  import lvlb_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [PW-1:0] wgray_q, rgray_q;
  logic [PW-1:0] w2r_s1, w2r_s2, r2w_s1, r2w_s2;
  logic [PW-1:0] wr_fill;
  logic          do_wr, do_rd;

  always_comb begin
    wr_fill  = wptr_q - PW'(gray2bin(GW'(r2w_s2)));
    full     = (wr_fill == PW'(DEPTH));
    rd_level = PW'(gray2bin(GW'(w2r_s2))) - rptr_q;
    empty    = (rd_level == '0);
    do_wr    = wr_en & ~full;
    do_rd    = rd_en & ~empty;
    wptr_d   = wptr_q + PW'(do_wr);
    rptr_d   = rptr_q + PW'(do_rd);
    rd_data  = mem[rptr_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      wgray_q <= '0;
      rgray_q <= '0;
      w2r_s1  <= '0;
      w2r_s2  <= '0;
      r2w_s1  <= '0;
      r2w_s2  <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      wgray_q <= PW'(bin2gray(GW'(wptr_d)));
      rgray_q <= PW'(bin2gray(GW'(rptr_d)));
      w2r_s1  <= wgray_q;
      w2r_s2  <= w2r_s1;
      r2w_s1  <= rgray_q;
      r2w_s2  <= r2w_s1;
    end
  end
endmodule

// File: rtl/lvlb_link_demux.sv
module lvlb_link_demux #(
  parameter int DATA_W    = 20,
  parameter int FIFO_AW   = 4,
  parameter int START_LVL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_trs,
  output logic [DATA_W-1:0] link_a,
  output logic [DATA_W-1:0] link_b,
  output logic              link_vld,
  output logic              hr_ce,
  output logic              fifo_err
);
  localparam int LW = FIFO_AW + 1;

  logic              wr_a, wr_b;
  logic [DATA_W-1:0] q_a, q_b;
  logic              full_a, full_b, empty_a, empty_b;
  logic [LW-1:0]     lvl_a, lvl_b;
  logic              ce_q, run_q, run_d, vld_q, vld_d, err_q, err_d;
  logic              load, go, pop;
  logic [DATA_W-1:0] a_q, a_d, b_q, b_d;

  lvlb_ldm_steer #(.W(DATA_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .rx_trs(rx_trs), .wr_a(wr_a), .wr_b(wr_b)
  );

  lvlb_ldm_fifo #(.W(DATA_W), .AW(FIFO_AW)) u_fifo_a (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .wr_data(rx_word), .rd_en(pop),
    .rd_data(q_a), .full(full_a), .empty(empty_a), .rd_level(lvl_a)
  );

  lvlb_ldm_fifo #(.W(DATA_W), .AW(FIFO_AW)) u_fifo_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .wr_data(rx_word), .rd_en(pop),
    .rd_data(q_b), .full(full_b), .empty(empty_b), .rd_level(lvl_b)
  );

  always_comb begin
    load  = ~ce_q;
    go    = run_q | ((lvl_a >= LW'(START_LVL)) & (lvl_b >= LW'(START_LVL)));
    pop   = load & go & ~empty_a & ~empty_b;
    run_d = run_q | (load & go);
    vld_d = load ? pop : vld_q;
    a_d   = pop ? q_a : a_q;
    b_d   = pop ? q_b : b_q;
    err_d = err_q | (wr_a & full_a) | (wr_b & full_b)
          | (load & run_q & (empty_a | empty_b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b0;
      run_q <= 1'b0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      ce_q  <= ~ce_q;
      run_q <= run_d;
      vld_q <= vld_d;
      err_q <= err_d;
      a_q   <= a_d;
      b_q   <= b_d;
    end
  end

  assign link_a   = a_q;
  assign link_b   = b_q;
  assign link_vld = vld_q;
  assign hr_ce    = ce_q;
  assign fifo_err = err_q;
endmodule

// File: rtl/lvlb_link_demux_chk.sv
module lvlb_link_demux_chk #(
  parameter int DATA_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_trs,
  input logic              wr_a,
  input logic              wr_b,
  input logic              hr_ce,
  input logic [DATA_W-1:0] link_a,
  input logic [DATA_W-1:0] link_b,
  input logic              link_vld,
  input logic              fifo_err
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_q | rx_trs;
  end

  AST_RST_QUIET: assert property (@(posedge clk) !rst_n |-> (!link_vld && !fifo_err && !hr_ce)); // R1
  AST_CE_FALL: assert property (@(posedge clk) disable iff (!rst_n) hr_ce |=> !hr_ce); // R2
  AST_CE_RISE: assert property (@(posedge clk) disable iff (!rst_n) !hr_ce |=> hr_ce); // R2
  AST_NO_PREALIGN: assert property (@(posedge clk) disable iff (!rst_n) (!seen_q && !rx_trs) |-> (!wr_a && !wr_b)); // R3
  AST_MARK_TO_A: assert property (@(posedge clk) disable iff (!rst_n) rx_trs |-> wr_a); // R4
  AST_A_THEN_B: assert property (@(posedge clk) disable iff (!rst_n) wr_a |=> (wr_b || rx_trs)); // R4
  AST_B_THEN_A: assert property (@(posedge clk) disable iff (!rst_n) wr_b |=> wr_a); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !hr_ce |-> ($stable(link_a) && $stable(link_b) && $stable(link_vld))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fifo_err |=> fifo_err); // R10
endmodule

bind lvlb_link_demux lvlb_link_demux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_trs(rx_trs), .wr_a(wr_a), .wr_b(wr_b),
  .hr_ce(hr_ce), .link_a(link_a), .link_b(link_b), .link_vld(link_vld),
  .fifo_err(fifo_err)
);

// File: tb/lvlb_link_demux_tb.sv
module lvlb_link_demux_tb;
  logic        clk;
  logic        rst_n;
  logic [19:0] rx_word;
  logic        rx_trs;
  logic [19:0] link_a, link_b;
  logic        link_vld, hr_ce, fifo_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [19:0] exp_a[$];
  logic [19:0] exp_b[$];
  int          ncap;
  bit          chk_on, have_prev, started;
  logic        prev_ce, prev_vld;
  logic [19:0] prev_a, prev_b;

  lvlb_link_demux u_dut (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_trs(rx_trs),
    .link_a(link_a), .link_b(link_b), .link_vld(link_vld),
    .hr_ce(hr_ce), .fifo_err(fifo_err)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic sample();
    if (chk_on) begin
      if (have_prev) begin
        check(hr_ce != prev_ce, "R2 hr_ce alternation", 20'(hr_ce), 20'(!prev_ce));
        if (!hr_ce)
          check(link_a == prev_a && link_b == prev_b && link_vld == prev_vld,
                "R8 hold while hr_ce low", link_a, prev_a);
      end
      if (hr_ce) begin
        if (link_vld) begin
          started = 1;
          if (ncap < exp_a.size()) begin
            check(link_a == exp_a[ncap], "R3 R4 R5 R6 link A word", link_a, exp_a[ncap]);
            check(link_b == exp_b[ncap], "R4 R5 R6 R7 link B word", link_b, exp_b[ncap]);
          end
          ncap++;
        end else if (started) begin
          check(1'b0, "R9 valid dropped", 20'(link_vld), 20'd1);
        end
      end
      have_prev = 1;
    end
    prev_ce = hr_ce; prev_vld = link_vld; prev_a = link_a; prev_b = link_b;
  endtask

  task automatic push(input logic [19:0] w, input logic t);
    @(negedge clk);
    sample();
    rx_word = w;
    rx_trs  = t;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; rx_trs = 0; rx_word = '0;
    chk_on = 0; have_prev = 0; started = 0; ncap = 0;
    exp_a.delete(); exp_b.delete();
    repeat (3) @(negedge clk);
    check(link_vld == 0, "R1 link_vld in reset", 20'(link_vld), 20'd0);
    check(fifo_err == 0, "R1 fifo_err in reset", 20'(fifo_err), 20'd0);
    check(hr_ce == 0, "R1 hr_ce in reset", 20'(hr_ce), 20'd0);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    check(hr_ce == 1, "R2 first cycle after reset", 20'(hr_ce), 20'd1);
    chk_on = 1;
    prev_ce = hr_ce; prev_vld = link_vld; prev_a = link_a; prev_b = link_b;
    have_prev = 1;
  endtask

  function automatic logic [9:0] smp(input int seed, input int s, input int l, input int k, input bit chroma);
    return 10'((seed + s * 97 + l * 13 + k * 5 + (chroma ? 211 : 0)) % 1000 + 4);
  endfunction

  task automatic run_scenario(input int garbage, input int lines, input int payload, input int seed);
    int framed;
    do_reset();
    for (int g = 0; g < garbage; g++) push({10'(g * 3 + 1), 10'h155}, 1'b0);
    for (int l = 0; l < lines; l++) begin
      for (int k = 0; k < 6 + payload; k++) begin
        logic [19:0] w1, w2;
        case (k)
          0: begin w1 = {10'h3FF, 10'h3FF}; w2 = w1; end
          1, 2: begin w1 = '0; w2 = '0; end
          3: begin w1 = {10'h200 | 10'(l), 10'h200 | 10'(l)}; w2 = w1; end
          4: begin w1 = {10'(l + 1), 10'(l + 2)}; w2 = {10'(l + 3), 10'(l + 4)}; end
          5: begin w1 = {10'h080, 10'h081}; w2 = {10'h082, 10'h083}; end
          default: begin
            w1 = {smp(seed, 1, l, k, 0), smp(seed, 1, l, k, 1)};
            w2 = {smp(seed, 2, l, k, 0), smp(seed, 2, l, k, 1)};
          end
        endcase
        exp_a.push_back(w1); exp_b.push_back(w2);
        push(w1, k == 0);
        push(w2, 1'b0);
      end
    end
    framed = exp_a.size();
    for (int f = 0; f < 24; f++) begin
      logic [19:0] w1, w2;
      w1 = {smp(seed, 3, f, f, 0), smp(seed, 3, f, f, 1)};
      w2 = {smp(seed, 4, f, f, 0), smp(seed, 4, f, f, 1)};
      exp_a.push_back(w1); exp_b.push_back(w2);
      push(w1, 1'b0);
      push(w2, 1'b0);
    end
    check(ncap >= framed, "R9 all framed words emitted", 20'(ncap), 20'(framed));
    check(fifo_err == 0, "R10 no error on continuous input", 20'(fifo_err), 20'd0);
    chk_on = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; rx_word = '0; rx_trs = 0;
    chk_on = 0; have_prev = 0; started = 0; ncap = 0;
    run_scenario(7, 3, 10, 11);
    run_scenario(4, 2, 16, 301);
    run_scenario(0, 4, 3, 555);
    finish_run();
  end
endmodule